// File: doc/BRIEF.md
# Flash Status Bit Generator

This block sits in the read path of a flash memory. When no embedded operation is running, each read returns the array data unchanged. While the embedded sequencer is programming, erasing or holding an erase in suspend, reads return a status word instead. In that word, bit 6 is a toggle bit for the device as a whole. Bit 2 is a toggle bit that only reads into sectors selected for erase advance. Bit 7 is a data-polling bit, and bit 5 flags an operation that has run past its time limit.

The sequencer drives a 3-bit mode code. It pulses `op_start_i` when an operation begins and `prot_abort_i` when a program or erase hits only protected sectors. The read logic pulses `rd_done_i` once per completed read cycle, whether OE or CE ended that cycle. The output word is registered. It is updated on the clock edge that samples the read pulse and held until the next read.

Top module: `flash_status_gen`

## Requirements
- R1: While reset is high, and on the first edge after it, `dout_o` is 0x00.
- R2: A read in idle mode (code 0, or any unused code 5 to 7) with no protected-abort window open returns `array_i` unchanged.
- R3: In program (code 1), erase (code 2) or suspend-program (code 4) mode, bit 6 of the returned word inverts on every read, at any address.
- R4: In erase-suspend mode (code 3), bit 6 holds its last value across reads.
- R5: Bit 2 inverts only on reads whose sector, taken from the top SECT_BITS address bits, has its bit set in `erase_sel_i`, and only in modes 2, 3 or 4. All other reads leave bit 2 unchanged.
- R6: In erase-suspend mode, a read into a sector not selected for erase returns `array_i`.
- R7: Bit 7 of a status word is the inverse of `prog_d7_i` in modes 1 and 4, is 1 in mode 3, and is 0 in mode 2 and in the abort window.
- R8: A `prot_abort_i` pulse opens a window of ABORT_CYC cycles after its edge. Idle-mode reads in that window return status with bit 6 inverting. Afterwards, idle-mode reads return array data.
- R9: Bit 5 is 1 once the mode has been in code 1, 2 or 4 for TLIMIT cycles since the last `op_start_i` or idle cycle, with suspend cycles not counted. Before that, bit 5 is 0.
- R10: Bits 4, 3, 1 and 0 of every status word are 0.
- R11: `dout_o` changes only on edges where `rd_done_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Sequencer mode: 0 idle, 1 program, 2 erase, 3 erase-suspend, 4 suspend-program |
| op_start_i | input | 1 | Pulse at the start of an operation; clears the time-limit counter |
| prot_abort_i | input | 1 | Pulse opening the protected-target toggle window |
| erase_sel_i | input | 2**SECT_BITS | Sectors selected for erase |
| prog_d7_i | input | 1 | Bit 7 of the data being programmed |
| rd_done_i | input | 1 | One pulse per completed read cycle |
| rd_addr_i | input | ADDR_W | Read address |
| array_i | input | 8 | Array data for the read address |
| dout_o | output | 8 | Registered read data or status word |

## Verification
A toggle flip-flop that advances wrongly shows on the very next read. Two reads in a row then return the same bit 6 or bit 2 where they should differ, or different values where they should match. A wrong sector decode shows the same way, as well as in the data-versus-status choice during suspend. Timer errors appear only at the window edges. An off-by-one in the abort counter flips one read from status to array data at cycle ABORT_CYC. A wrong time-limit count moves the edge where bit 5 rises, and that is visible on the first read after TLIMIT active cycles.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int DQ_W = 8;

  typedef enum logic [2:0] {
    SEQ_IDLE      = 3'd0,
    SEQ_PROG      = 3'd1,
    SEQ_ERASE     = 3'd2,
    SEQ_SUSP      = 3'd3,
    SEQ_SUSP_PROG = 3'd4
  } seq_mode_e;

  // modes in which the embedded algorithm is actually running
  function automatic logic mode_running(input logic [2:0] m);
    return (m == SEQ_PROG) || (m == SEQ_ERASE) || (m == SEQ_SUSP_PROG);
  endfunction

  // modes in which an erase is in progress or parked
  function automatic logic mode_erasing(input logic [2:0] m);
    return (m == SEQ_ERASE) || (m == SEQ_SUSP) || (m == SEQ_SUSP_PROG);
  endfunction

endpackage

// File: rtl/fsb_sector_match.sv
module fsb_sector_match #(
  parameter int ADDR_W    = 16,
  parameter int SECT_BITS = 3
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [(1<<SECT_BITS)-1:0]  sel_i,
  output logic                       hit_o
);
  localparam int NSECT = 1 << SECT_BITS;

  logic [SECT_BITS-1:0] sect;
  logic [NSECT-1:0]     hit_vec;

  assign sect = addr_i[ADDR_W-1 -: SECT_BITS];

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign hit_vec[s] = sel_i[s] && (sect == SECT_BITS'(s));
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/fsb_timers.sv
module fsb_timers #(
  parameter int ABORT_CYC = 500,
  parameter int TLIMIT    = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic abort_start_i,
  input  logic op_start_i,
  input  logic running_i,
  input  logic idle_i,
  output logic abort_active_o,
  output logic limit_hit_o
);
  localparam int AW = $clog2(ABORT_CYC + 1);
  localparam int TW = $clog2(TLIMIT + 1);

  logic [AW-1:0] abort_cnt;
  logic [TW-1:0] op_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 abort_cnt <= '0;
    else if (abort_start_i)  abort_cnt <= AW'(ABORT_CYC);
    else if (abort_cnt != 0) abort_cnt <= abort_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || op_start_i || idle_i)               op_cnt <= '0;
    else if (running_i && op_cnt != TW'(TLIMIT))   op_cnt <= op_cnt + 1'b1;
  end

  assign abort_active_o = (abort_cnt != 0);
  assign limit_hit_o    = (op_cnt == TW'(TLIMIT));
endmodule

// File: rtl/fsb_toggle.sv
module fsb_toggle (
  input  logic clk,
  input  logic rst,
  input  logic adv6_i,
  input  logic adv2_i,
  output logic t6_o,
  output logic t2_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      t6_o <= 1'b0;
      t2_o <= 1'b0;
    end else begin
      if (adv6_i) t6_o <= ~t6_o;
      if (adv2_i) t2_o <= ~t2_o;
    end
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_BITS = 3,
  parameter int ABORT_CYC = 500,
  parameter int TLIMIT    = 2000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 mode_i,
  input  logic                       op_start_i,
  input  logic                       prot_abort_i,
  input  logic [(1<<SECT_BITS)-1:0]  erase_sel_i,
  input  logic                       prog_d7_i,
  input  logic                       rd_done_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  input  logic [DQ_W-1:0]            array_i,
  output logic [DQ_W-1:0]            dout_o
);
  logic running, erasing, susp, idle_m;
  logic sect_hit, abort_active, limit_hit;
  logic t6, t2, adv6, adv2, status_sel, dq7;
  logic [DQ_W-1:0] status_word;

  assign running = mode_running(mode_i);
  assign erasing = mode_erasing(mode_i);
  assign susp    = (mode_i == SEQ_SUSP);
  assign idle_m  = !(running || susp);

  fsb_sector_match #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_match (
    .addr_i (rd_addr_i),
    .sel_i  (erase_sel_i),
    .hit_o  (sect_hit)
  );

  fsb_timers #(.ABORT_CYC(ABORT_CYC), .TLIMIT(TLIMIT)) u_timers (
    .clk            (clk),
    .rst            (rst),
    .abort_start_i  (prot_abort_i),
    .op_start_i     (op_start_i),
    .running_i      (running),
    .idle_i         (idle_m),
    .abort_active_o (abort_active),
    .limit_hit_o    (limit_hit)
  );

  assign adv6 = rd_done_i && (running || (idle_m && abort_active));
  assign adv2 = rd_done_i && sect_hit && erasing;

  fsb_toggle u_toggle (
    .clk    (clk),
    .rst    (rst),
    .adv6_i (adv6),
    .adv2_i (adv2),
    .t6_o   (t6),
    .t2_o   (t2)
  );

  assign status_sel = running || (susp && sect_hit) || (idle_m && abort_active);

  always_comb begin
    unique case (mode_i)
      SEQ_PROG, SEQ_SUSP_PROG: dq7 = ~prog_d7_i;
      SEQ_SUSP:                dq7 = 1'b1;
      default:                 dq7 = 1'b0;
    endcase
  end

  assign status_word = {dq7, t6, limit_hit, 2'b00, t2, 2'b00};

  always_ff @(posedge clk) begin
    if (rst)            dout_o <= '0;
    else if (rd_done_i) dout_o <= status_sel ? status_word : array_i;
  end
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_i,
  input logic       rd_done_i,
  input logic       prot_abort_i,
  input logic [7:0] array_i,
  input logic [7:0] dout_o,
  input logic       sect_hit,
  input logic       abort_active,
  input logic       limit_hit,
  input logic       status_sel,
  input logic       t6,
  input logic       t2
);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_done_i)) |-> $stable(dout_o));

  p_idle_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_done_i) && $past(mode_i) == 3'd0 && !$past(abort_active))
      |-> dout_o == $past(array_i));

  p_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_done_i) && $past(mode_i) == 3'd1) |-> t6 != $past(t6));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) == 3'd3) |-> t6 == $past(t6));

  p_sector_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(rd_done_i) && $past(sect_hit))) |-> t2 == $past(t2));

  p_poll_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_done_i) && $past(mode_i) == 3'd3 && $past(sect_hit))
      |-> dout_o[7]);

  p_window_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(abort_active)) |-> $past(prot_abort_i));

  p_limit_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(limit_hit)) |-> $past(mode_i) != 3'd0);

  p_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_done_i) && $past(status_sel))
      |-> (dout_o[4:3] == 2'b00 && dout_o[1:0] == 2'b00));
endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_i       (mode_i),
  .rd_done_i    (rd_done_i),
  .prot_abort_i (prot_abort_i),
  .array_i      (array_i),
  .dout_o       (dout_o),
  .sect_hit     (sect_hit),
  .abort_active (abort_active),
  .limit_hit    (limit_hit),
  .status_sel   (status_sel),
  .t6           (t6),
  .t2           (t2)
);

// File: tb/flash_status_gen_bench.sv
`timescale 1ns/1ps
module flash_status_gen_bench;
  localparam int ADDR_W = 16, SECT_BITS = 3, ABORT_CYC = 500, TLIMIT = 2000;
  localparam int NSECT = 1 << SECT_BITS;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic op_start = 0, prot_abort = 0, prog_d7 = 0, rd_done = 0;
  logic [NSECT-1:0] erase_sel = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] arr = '0, dout;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit m_t6 = 0, m_t2 = 0;
  int m_acnt = 0, m_tcnt = 0;
  logic [7:0] m_dout = 8'h00;

  always #2 clk = ~clk;

  flash_status_gen #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
                     .ABORT_CYC(ABORT_CYC), .TLIMIT(TLIMIT)) u_flash_status_gen (
    .clk(clk), .rst(rst), .mode_i(mode), .op_start_i(op_start),
    .prot_abort_i(prot_abort), .erase_sel_i(erase_sel), .prog_d7_i(prog_d7),
    .rd_done_i(rd_done), .rd_addr_i(addr), .array_i(arr), .dout_o(dout));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit f_running(input logic [2:0] m);
    return m == 3'd1 || m == 3'd2 || m == 3'd4;
  endfunction

  // one clock: predict from inputs, advance reference, compare after edge
  task automatic cyc();
    bit run, sus, idl, hit, erz, stat, readc;
    int sect;
    string t6tag, ptag;
    run  = f_running(mode);
    sus  = (mode == 3'd3);
    idl  = !(run || sus);
    sect = int'(addr[ADDR_W-1 -: SECT_BITS]);
    hit  = erase_sel[sect];
    erz  = (mode == 3'd2 || mode == 3'd3 || mode == 3'd4);
    stat = run || (sus && hit) || (idl && m_acnt != 0);
    readc = rd_done;
    t6tag = sus ? "R4" : (idl ? "R8" : "R3");
    ptag  = sus ? "R6" : ((m_acnt != 0) ? "R8" : "R2");
    if (rd_done) begin
      if (stat)
        m_dout = {(mode == 3'd1 || mode == 3'd4) ? ~prog_d7 : (sus ? 1'b1 : 1'b0),
                  m_t6, (m_tcnt == TLIMIT), 2'b00, m_t2, 2'b00};
      else
        m_dout = arr;
      if (run || (idl && m_acnt != 0)) m_t6 = !m_t6;
      if (hit && erz) m_t2 = !m_t2;
    end
    if (prot_abort) m_acnt = ABORT_CYC; else if (m_acnt != 0) m_acnt--;
    if (op_start || idl) m_tcnt = 0; else if (run && m_tcnt != TLIMIT) m_tcnt++;
    @(negedge clk);
    if (!readc) chk("R11", dout, m_dout);
    else if (!stat) chk(ptag, dout, m_dout);
    else begin
      chk(t6tag, dout[6], m_dout[6]);
      chk("R5", dout[2], m_dout[2]);
      chk("R7", dout[7], m_dout[7]);
      chk("R9", dout[5], m_dout[5]);
      chk("R10", {dout[4:3], dout[1:0]}, 0);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int hold;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1", dout, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", dout, 0);

    // directed: idle pass-through
    rd_done = 1; arr = 8'hA5; cyc();
    arr = 8'h3C; cyc();
    rd_done = 0; arr = 8'hFF; cyc();

    // directed: abort window start and end
    prot_abort = 1; cyc(); prot_abort = 0;
    for (int i = 0; i < ABORT_CYC + 10; i++) begin
      rd_done = (i % 3 == 0) || (i >= ABORT_CYC - 3);
      arr = 8'(i); cyc();
    end

    // directed: time-limit flag in program mode
    mode = 3'd1; op_start = 1; prog_d7 = 1; rd_done = 1; cyc(); op_start = 0;
    for (int i = 0; i < TLIMIT + 20; i++) begin
      rd_done = (i % 4 == 0) || (i >= TLIMIT - 4 && i <= TLIMIT + 4);
      cyc();
    end

    // directed: erase then suspend, in and out of selected sectors
    mode = 3'd2; op_start = 1; erase_sel = 8'b0000_0101; cyc(); op_start = 0;
    for (int i = 0; i < 16; i++) begin
      rd_done = 1; addr = {3'(i % 8), 13'h0}; arr = 8'h5A; cyc();
    end
    mode = 3'd3;
    for (int i = 0; i < 16; i++) begin
      rd_done = 1; addr = {3'(i % 8), 13'h11}; arr = 8'(8'hC0 + i); cyc();
    end
    mode = 3'd4; prog_d7 = 0;
    for (int i = 0; i < 8; i++) begin rd_done = 1; addr = {3'(i), 13'h2}; cyc(); end

    // constrained random
    mode = 3'd0; cyc();
    for (int blk = 0; blk < 900; blk++) begin
      logic [2:0] nm;
      nm = 3'($urandom_range(0, 7));
      op_start = (mode == 3'd0 && f_running(nm)) || ($urandom_range(0, 9) == 0);
      prot_abort = (nm == 3'd0) && ($urandom_range(0, 5) == 0);
      if (nm == 3'd2 || mode == 3'd0) erase_sel = 8'($urandom);
      mode = nm; prog_d7 = 1'($urandom);
      hold = $urandom_range(1, 40);
      for (int c = 0; c < hold; c++) begin
        rd_done = 1'($urandom);
        addr = 16'($urandom);
        arr = 8'($urandom);
        cyc();
        op_start = 0; prot_abort = 0;
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule